// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between an internal single-word request/acknowledge bus and an external asynchronous static RAM of 65,536 sixteen-bit words whose control strobes are all active low. A request carries an address, write data, a read/write flag and one enable bit per byte lane. The controller turns it into a timed strobe sequence on the memory pins and answers with a one-cycle done pulse. Reads also return the captured word.

A write opens the chip select, drives the data bus, and pulses the write strobe inside that window for a set number of cycles. Address and lane enables stay frozen on both sides of the pulse. A read never drives the bus. It holds the output strobe low for a programmable number of wait cycles that must cover the memory's 10 to 15 ns access time at the chosen clock. The word is captured on the last of those cycles. Bus release comes before the output strobe every time, so controller and memory never drive the pins at once. The bidirectional data pins are handled as an output value, an output-enable and an input value, and the pad cell sits outside the block.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset and whenever the controller is idle, `req_ready` is 1. Chip select, write strobe, output strobe and every lane enable on the memory side are high. `mem_dq_oe` is 0.
- R2: A write accepted at a clock edge keeps chip select low for SETUP_CYC + WE_CYC + HOLD_CYC cycles. The write strobe is low for exactly WE_CYC consecutive cycles, starting in busy cycle SETUP_CYC + 1. The done pulse comes in the cycle after the last busy cycle, and the memory then holds the written lanes.
- R3: Throughout an access, `mem_be_n[0]` is the inverse of `req_be[0]` and selects data bits 7:0. `mem_be_n[1]` is the inverse of `req_be[1]` and selects bits 15:8. Any combination of the two is allowed.
- R4: `mem_addr` and `mem_be_n` hold the latched request values for the whole access. In particular they do not change in the cycle after any cycle with the write strobe low.
- R5: `mem_dq_oe` is 1 in every busy cycle of a write, with `mem_dq_out` equal to the write data, and 0 in every other cycle.
- R6: A read spends one busy cycle with the output strobe high, then RD_WAIT cycles with it low. The write strobe stays high the whole time.
- R7: Read data is sampled in the last wait cycle. `rsp_done` is high for exactly one cycle, the cycle after it. Bits of a lane whose enable was 0 come back as zero. `rsp_rdata` keeps its value until the next read completes.
- R8: The output strobe never falls in a cycle that follows a cycle with `mem_dq_oe` high, and `mem_dq_oe` is never 1 while the output strobe is low.
- R9: While busy, `req_ready` is 0 and a `req_valid` pulse is ignored. It starts no access and changes no memory word.
- R10: The cycle with `rsp_done` high is already idle, so a new request can be accepted in it. The rules of R5 and R8 still hold across that back-to-back turnaround.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_ready | output | 1 | Idle, able to accept a request |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Captured read word, disabled lanes zero |
| mem_addr | output | 16 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_be_n | output | 2 | Lane enables, active low, bit 0 = bits 7:0 |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | 16 | Data read from the memory pins |

## Verification
The completion of one access and the acceptance of the next can fall in the same cycle. The done pulse of a read or write arrives in the cycle where the controller is already idle. The bench provokes this by driving a new request in the very cycle it sees `rsp_done`, in all four read/write orderings, both in directed cases and at random. Each such pairing is judged by checking that the second access still shows the full setup, strobe and wait counts. During a read that follows a write, the bus drive must stay off in every cycle, and the first access's data must still be correct in the memory model.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WSETUP  = 3'd1,
        ST_WPULSE  = 3'd2,
        ST_WHOLD   = 3'd3,
        ST_RSETUP  = 3'd4,
        ST_RWAIT   = 3'd5
    } seq_state_e;

    localparam int LANE_W = 8;

endpackage

// File: rtl/sram_lane_mask.sv
module sram_lane_mask
    import sram_ctrl_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0]        data_i,
    input  logic [DATA_W/LANE_W-1:0] be_n_i,
    output logic [DATA_W-1:0]        data_o
);
    localparam int LANES = DATA_W / LANE_W;

    // A lane whose enable is inactive returns zero instead of floating pins
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign data_o[l*LANE_W +: LANE_W] =
            be_n_i[l] ? '0 : data_i[l*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int SETUP_CYC = 1,
    parameter int WE_CYC    = 2,
    parameter int HOLD_CYC  = 1,
    parameter int RD_WAIT   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [DATA_W/LANE_W-1:0] req_be,
    input  logic [DATA_W-1:0]        rd_masked,
    output logic                     ready,
    output logic                     done,
    output logic [DATA_W-1:0]        rdata,
    output logic [ADDR_W-1:0]        addr,
    output logic                     ce_n,
    output logic                     we_n,
    output logic                     oe_n,
    output logic [DATA_W/LANE_W-1:0] be_n,
    output logic [DATA_W-1:0]        dq_out,
    output logic                     dq_oe
);
    localparam int LANES = DATA_W / LANE_W;
    localparam int M1    = (SETUP_CYC > WE_CYC) ? SETUP_CYC : WE_CYC;
    localparam int M2    = (HOLD_CYC > RD_WAIT) ? HOLD_CYC : RD_WAIT;
    localparam int MAXC  = (M1 > M2) ? M1 : M2;
    localparam int CNT_W = $clog2(MAXC + 1);

    localparam logic [CNT_W-1:0] C_SETUP = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] C_WE    = CNT_W'(WE_CYC - 1);
    localparam logic [CNT_W-1:0] C_HOLD  = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] C_RD    = CNT_W'(RD_WAIT - 1);

    typedef struct packed {
        seq_state_e         st;
        logic [CNT_W-1:0]   cnt;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        logic [DATA_W-1:0]  rdata;
        logic [LANES-1:0]   be_n;
        logic               ce_n;
        logic               we_n;
        logic               oe_n;
        logic               dq_oe;
        logic               done;
    } seq_reg_t;

    localparam seq_reg_t RST_VAL = '{
        st:    ST_IDLE,
        cnt:   '0,
        addr:  '0,
        wdata: '0,
        rdata: '0,
        be_n:  '1,
        ce_n:  1'b1,
        we_n:  1'b1,
        oe_n:  1'b1,
        dq_oe: 1'b0,
        done:  1'b0
    };

    seq_reg_t r_d, r_q;
    logic     cnt_zero;

    assign cnt_zero = (r_q.cnt == '0);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.be_n  = ~req_be;
                    r_d.ce_n  = 1'b0;
                    if (req_write) begin
                        r_d.st    = ST_WSETUP;
                        r_d.cnt   = C_SETUP;
                        r_d.dq_oe = 1'b1;
                    end else begin
                        r_d.st    = ST_RSETUP;
                        r_d.cnt   = '0;
                    end
                end
            end
            ST_WSETUP: begin
                if (cnt_zero) begin
                    r_d.st   = ST_WPULSE;
                    r_d.we_n = 1'b0;
                    r_d.cnt  = C_WE;
                end else begin
                    r_d.cnt  = r_q.cnt - CNT_W'(1);
                end
            end
            ST_WPULSE: begin
                if (cnt_zero) begin
                    r_d.st   = ST_WHOLD;
                    r_d.we_n = 1'b1;
                    r_d.cnt  = C_HOLD;
                end else begin
                    r_d.cnt  = r_q.cnt - CNT_W'(1);
                end
            end
            ST_WHOLD: begin
                if (cnt_zero) begin
                    r_d.st    = ST_IDLE;
                    r_d.ce_n  = 1'b1;
                    r_d.be_n  = '1;
                    r_d.dq_oe = 1'b0;
                    r_d.done  = 1'b1;
                end else begin
                    r_d.cnt   = r_q.cnt - CNT_W'(1);
                end
            end
            ST_RSETUP: begin
                r_d.st   = ST_RWAIT;
                r_d.oe_n = 1'b0;
                r_d.cnt  = C_RD;
            end
            ST_RWAIT: begin
                if (cnt_zero) begin
                    r_d.st    = ST_IDLE;
                    r_d.rdata = rd_masked;
                    r_d.ce_n  = 1'b1;
                    r_d.oe_n  = 1'b1;
                    r_d.be_n  = '1;
                    r_d.done  = 1'b1;
                end else begin
                    r_d.cnt   = r_q.cnt - CNT_W'(1);
                end
            end
            default: begin
                r_d = RST_VAL;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= RST_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign ready  = (r_q.st == ST_IDLE);
    assign done   = r_q.done;
    assign rdata  = r_q.rdata;
    assign addr   = r_q.addr;
    assign ce_n   = r_q.ce_n;
    assign we_n   = r_q.we_n;
    assign oe_n   = r_q.oe_n;
    assign be_n   = r_q.be_n;
    assign dq_out = r_q.wdata;
    assign dq_oe  = r_q.dq_oe;
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int SETUP_CYC = 1,
    parameter int WE_CYC    = 2,
    parameter int HOLD_CYC  = 1,
    parameter int RD_WAIT   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [DATA_W/8-1:0]      req_be,
    output logic                     req_ready,
    output logic                     rsp_done,
    output logic [DATA_W-1:0]        rsp_rdata,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic                     mem_ce_n,
    output logic                     mem_we_n,
    output logic                     mem_oe_n,
    output logic [DATA_W/8-1:0]      mem_be_n,
    output logic [DATA_W-1:0]        mem_dq_out,
    output logic                     mem_dq_oe,
    input  logic [DATA_W-1:0]        mem_dq_in
);
    logic [DATA_W-1:0] rd_masked;

    sram_lane_mask #(
        .DATA_W (DATA_W)
    ) u_mask (
        .data_i (mem_dq_in),
        .be_n_i (mem_be_n),
        .data_o (rd_masked)
    );

    sram_ctrl_seq #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .SETUP_CYC (SETUP_CYC),
        .WE_CYC    (WE_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .RD_WAIT   (RD_WAIT)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .rd_masked (rd_masked),
        .ready     (req_ready),
        .done      (rsp_done),
        .rdata     (rsp_rdata),
        .addr      (mem_addr),
        .ce_n      (mem_ce_n),
        .we_n      (mem_we_n),
        .oe_n      (mem_oe_n),
        .be_n      (mem_be_n),
        .dq_out    (mem_dq_out),
        .dq_oe     (mem_dq_oe)
    );
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
    parameter int ADDR_W = 16,
    parameter int LANES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [LANES-1:0]  mem_be_n,
    input logic              mem_dq_oe
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && (&mem_be_n) && !mem_dq_oe));

    // R2
    we_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n));

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |=> ($stable(mem_addr) && $stable(mem_be_n)));

    // R5
    bus_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_ce_n && mem_oe_n));

    // R6
    read_we_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R8
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));

    // R9
    busy_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> !mem_ce_n);
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .LANES  (DATA_W/8)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_be_n  (mem_be_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_lane_ctrl_tb.sv
`timescale 1ns/100ps
module sram_lane_ctrl_tb;
    localparam int SETUP = 1;
    localparam int WEC   = 2;
    localparam int HOLD  = 1;
    localparam int RDW   = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rsp_done;
    logic [15:0] rsp_rdata, mem_addr, mem_dq_out;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [1:0]  mem_be_n;
    logic [15:0] mem_dq_in;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int oe_cnt = 0;
    logic [15:0] last_rd = '0;

    logic [15:0] exp_mem [logic [15:0]];
    logic [15:0] mdl     [logic [15:0]];

    always #2.5 clk = ~clk;

    sram_lane_ctrl #(
        .SETUP_CYC (SETUP), .WE_CYC (WEC), .HOLD_CYC (HOLD), .RD_WAIT (RDW)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
        .req_wdata (req_wdata), .req_be (req_be),
        .req_ready (req_ready), .rsp_done (rsp_done), .rsp_rdata (rsp_rdata),
        .mem_addr (mem_addr), .mem_ce_n (mem_ce_n), .mem_we_n (mem_we_n),
        .mem_oe_n (mem_oe_n), .mem_be_n (mem_be_n), .mem_dq_out (mem_dq_out),
        .mem_dq_oe (mem_dq_oe), .mem_dq_in (mem_dq_in)
    );

    // Behavioural memory: write lands when the write strobe rises inside chip select
    always @(posedge mem_we_n) begin
        if (mem_ce_n === 1'b0 && mem_dq_oe === 1'b1) begin
            logic [15:0] w;
            w = mdl.exists(mem_addr) ? mdl[mem_addr] : 16'h0000;
            if (!mem_be_n[0]) w[7:0]  = mem_dq_out[7:0];
            if (!mem_be_n[1]) w[15:8] = mem_dq_out[15:8];
            mdl[mem_addr] = w;
        end
    end

    always @(posedge clk) begin
        if (mem_oe_n !== 1'b0) oe_cnt <= 0;
        else                   oe_cnt <= oe_cnt + 1;
    end

    // Read side: data valid only after the access time, floating lanes read as junk
    always @* begin
        logic [15:0] s;
        logic        v;
        s = mdl.exists(mem_addr) ? mdl[mem_addr] : 16'h0000;
        v = (mem_ce_n === 1'b0) && (mem_oe_n === 1'b0) && (mem_we_n === 1'b1)
            && (oe_cnt >= RDW - 1);
        mem_dq_in[7:0]  = (v && !mem_be_n[0]) ? s[7:0]  : 8'hA5;
        mem_dq_in[15:8] = (v && !mem_be_n[1]) ? s[15:8] : 8'h5A;
    end

    function automatic logic [15:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic logic [15:0] exp_read(input logic [15:0] a, input logic [1:0] be);
        logic [15:0] v;
        v = exp_mem.exists(a) ? exp_mem[a] : 16'h0000;
        return v & lane_mask(be);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic poke_busy(input int i, input logic [15:0] a);
        if (i == 2) begin
            chk(!req_ready, "R9 ready low while busy", 32'(req_ready), 0);
            req_valid = 1'b1;
            req_write = 1'b1;
            req_addr  = a ^ 16'h0100;
            req_wdata = 16'(~$urandom);
            req_be    = 2'b11;
        end
        if (i == 3) req_valid = 1'b0;
    endtask

    // Called at a falling edge; returns at the falling edge where done is seen
    task automatic do_write(input logic [15:0] a, input logic [15:0] d,
                            input logic [1:0] be, input bit poke);
        int n = 0, we_lo = 0, first_we = 0, bad_lane = 0, bad_addr = 0, bad_bus = 0;
        chk(req_ready, "R10 ready at request", 32'(req_ready), 1);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
        for (int i = 1; i <= 64; i++) begin
            @(negedge clk);
            if (i == 1) begin
                req_valid = 1'b0; req_addr = 16'($urandom); req_wdata = 16'($urandom);
                req_be = 2'($urandom);
            end
            if (poke) poke_busy(i, a);
            if (rsp_done) begin n = i; break; end
            if (mem_be_n != ~be) bad_lane++;
            if (mem_addr != a) bad_addr++;
            if (!mem_dq_oe || mem_dq_out != d || mem_ce_n) bad_bus++;
            if (!mem_we_n) begin we_lo++; if (first_we == 0) first_we = i; end
        end
        req_valid = 1'b0;
        chk(n == SETUP + WEC + HOLD + 1, "R2 write done cycle", n, SETUP + WEC + HOLD + 1);
        chk(we_lo == WEC, "R2 write strobe length", we_lo, WEC);
        chk(first_we == SETUP + 1, "R2 write strobe start", first_we, SETUP + 1);
        chk(bad_lane == 0, "R3 lane enables during write", bad_lane, 0);
        chk(bad_addr == 0, "R4 address during write", bad_addr, 0);
        chk(bad_bus == 0, "R5 bus driven with write data", bad_bus, 0);
        chk(!mem_dq_oe && mem_ce_n && mem_we_n && mem_oe_n && (&mem_be_n),
            "R1 quiet after write", {mem_dq_oe, mem_ce_n, mem_we_n, mem_oe_n, mem_be_n}, 6'h1F);
        chk(req_ready, "R10 ready with done", 32'(req_ready), 1);
        exp_mem[a] = (exp_read(a, 2'b11) & ~lane_mask(be)) | (d & lane_mask(be));
    endtask

    task automatic do_read(input logic [15:0] a, input logic [1:0] be, input bit poke);
        int n = 0, oe_lo = 0, first_oe = 0, bad_lane = 0, bad_addr = 0, bad_we = 0, bad_dq = 0;
        logic [15:0] e;
        e = exp_read(a, be);
        chk(req_ready, "R10 ready at request", 32'(req_ready), 1);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be;
        req_wdata = 16'($urandom);
        for (int i = 1; i <= 64; i++) begin
            @(negedge clk);
            if (i == 1) begin
                req_valid = 1'b0; req_addr = 16'($urandom); req_be = 2'($urandom);
            end
            if (poke) poke_busy(i, a);
            if (rsp_done) begin n = i; break; end
            if (mem_be_n != ~be) bad_lane++;
            if (mem_addr != a) bad_addr++;
            if (!mem_we_n || mem_ce_n) bad_we++;
            if (mem_dq_oe) bad_dq++;
            if (!mem_oe_n) begin oe_lo++; if (first_oe == 0) first_oe = i; end
        end
        req_valid = 1'b0;
        chk(n == RDW + 2, "R7 read done cycle", n, RDW + 2);
        chk(oe_lo == RDW, "R6 output strobe length", oe_lo, RDW);
        chk(first_oe == 2, "R6 output strobe after one setup cycle", first_oe, 2);
        chk(bad_we == 0, "R6 write strobe high in read", bad_we, 0);
        chk(bad_lane == 0, "R3 lane enables during read", bad_lane, 0);
        chk(bad_addr == 0, "R4 address during read", bad_addr, 0);
        chk(bad_dq == 0, "R8 bus released during read", bad_dq, 0);
        chk(rsp_rdata == e, "R7 read data with zeroed lanes", rsp_rdata, e);
        last_rd = e;
    endtask

    task automatic idle_check();
        @(negedge clk);
        chk(!rsp_done, "R7 done lasts one cycle", 32'(rsp_done), 0);
        chk(rsp_rdata == last_rd, "R7 read data held", rsp_rdata, last_rd);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=<%0d", cyc, 100000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_done && !mem_dq_oe, "R1 reset ready state",
            {req_ready, rsp_done, mem_dq_oe}, 3'b100);
        chk(mem_ce_n && mem_we_n && mem_oe_n && (&mem_be_n), "R1 reset strobes high",
            {mem_ce_n, mem_we_n, mem_oe_n, mem_be_n}, 5'h1F);
        chk(rsp_rdata == 16'h0, "R1 reset read data", rsp_rdata, 0);

        // Directed corners: address extremes, single lanes, empty lane set
        do_write(16'hFFFF, 16'hC3E1, 2'b11, 1'b0);
        do_read (16'hFFFF, 2'b11, 1'b0);                 // R10 write then read back to back
        idle_check();
        do_write(16'h0000, 16'h1234, 2'b01, 1'b0);
        do_read (16'h0000, 2'b11, 1'b0);                 // R3 upper lane untouched
        do_write(16'h0000, 16'hAB99, 2'b10, 1'b1);       // R9 poke while busy
        do_read (16'h0000, 2'b11, 1'b0);
        do_read (16'h0000, 2'b01, 1'b0);                 // R7 upper lane zero
        do_read (16'h0000, 2'b00, 1'b1);                 // R7 no lanes, R9 poke
        do_read (16'h0100, 2'b11, 1'b0);                 // R9 poked address unchanged
        idle_check();
        do_write(16'h0100, 16'h0F0F, 2'b00, 1'b0);       // R3 no lane written
        do_read (16'h0100, 2'b11, 1'b0);
        do_write(16'h0100, 16'h7777, 2'b11, 1'b0);       // R10 read then write

        for (int k = 0; k < 300; k++) begin
            logic [15:0] a;
            logic [1:0]  be;
            a  = 16'($urandom) & 16'h011F;
            be = 2'($urandom);
            if ($urandom % 2 == 0) do_write(a, 16'($urandom), be, ($urandom % 4) == 0);
            else                   do_read (a, be, ($urandom % 4) == 0);
            if ($urandom % 3 == 0) idle_check();
        end

        for (int a = 0; a < 32; a++) begin
            do_read(16'(a), 2'b11, 1'b0);
            do_read(16'(a) | 16'h0100, 2'b11, 1'b0);
        end

        idle_check();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule